// File: doc/BRIEF.md
# Three-Channel Measurement Sequencer

The block orders the measurements of a three-channel monitor, where each channel has a shunt-voltage reading and a bus-voltage reading. A configuration write supplies a 3-bit mode code and one enable bit per channel. The sequencer then walks through the enabled channels. For each one it requests the shunt measurement first and the bus measurement second from an external converter, using a start/done handshake. Each request carries a tag that gives the channel index and the measurement type. The returned value is stored in the matching result register, and that register keeps its value until the same tag completes again.

The mode code sets three things: whether the shunt measurement, the bus measurement or both are taken; whether the block loops forever or makes a single pass and then powers down; and whether the block powers down at once. Leaving power-down costs a fixed number of wake-up cycles before the first request. A ready flag reports that a full pass has finished. Configuration writes clear it, except writes that select power-down, and a status-read strobe also clears it. A write that arrives while a conversion is in flight restarts the pass. The block waits for the abandoned result and throws it away before it issues a new request.

Top module: `mon_conv_seq`

## Requirements
- R1: After reset the block is powered down (`pwr_down_o`=1), `conv_rdy_o` is 0, every result register is 0 and no start is issued.
- R2: Enabled channels are visited in ascending index order. Within a channel that needs both readings, the shunt request (`adc_bus_o`=0) comes before the bus request (`adc_bus_o`=1). In a continuous mode the order wraps from the highest enabled channel back to the lowest without a gap.
- R3: A channel whose enable bit (bit c of `cfg_chen_i` for channel c) is 0 never receives a start, in any mode.
- R4: Mode code bits select what is measured. Bit 0 set means shunt readings are taken and bit 1 set means bus readings are taken. Codes 001 and 101 are shunt-only, 010 and 110 are bus-only, 011 and 111 take both.
- R5: Codes 001, 010 and 011 are single-shot. One pass over the enabled channels is made, then `pwr_down_o` rises on the clock edge that accepts the last done, and no further start is issued. Codes 000 and 100 enter power-down on the edge that samples the write.
- R6: Writing a single-shot code again starts a new pass, even when the value is identical to the previous write.
- R7: `conv_rdy_o` rises only on the edge that accepts the last done of a pass. In continuous codes (101, 110, 111) this happens at the end of every pass.
- R8: A write of an active code (low two bits non-zero) clears `conv_rdy_o`. A write of a power-down code leaves it unchanged. A pulse on `flag_rd_i` clears it, unless a pass ends on the same edge.
- R9: When an active code is written while the block is powered down, the first start is high in the cycle that begins WAKE_CYC clock edges after the edge that sampled the write.
- R10: A write while a conversion is outstanding restarts the pass from the lowest enabled step. The outstanding result is discarded and leaves all result registers unchanged. No new start is issued until that done has returned.
- R11: With no channel enabled no start is issued. A single-shot write then sets `conv_rdy_o` and powers down on the edge that samples it.
- R12: A result register changes only on an accepted done, and only for the tag of that conversion. It can be read at any time, including in power-down.
- R13: `adc_start_o` is a one-cycle pulse. It is never asserted while a conversion is outstanding, and each start receives exactly one done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 3 | Mode code written with the strobe |
| cfg_chen_i | input | NCH | Channel enable bits, bit c for channel c |
| flag_rd_i | input | 1 | Status-read strobe; clears the ready flag |
| adc_start_o | output | 1 | Conversion request pulse |
| adc_chan_o | output | $clog2(NCH) | Channel tag of the request |
| adc_bus_o | output | 1 | Type tag: 0 shunt, 1 bus |
| adc_done_i | input | 1 | Conversion complete pulse |
| adc_data_i | input | DW | Conversion result, valid with done |
| shunt_res_o | output | NCH*DW | Shunt results, channel c at bits c*DW |
| bus_res_o | output | NCH*DW | Bus results, channel c at bits c*DW |
| conv_rdy_o | output | 1 | Pass-complete flag |
| pwr_down_o | output | 1 | Block is powered down |

## Verification
The assertions check the following on every cycle: starts are single pulses; disabled channels are never started; the shunt-only and bus-only codes never issue the wrong type; no start is issued in power-down; result registers are stable when no done arrives; and the ready flag obeys its set and clear rules. Other behaviour only the bench scenarios can show. This covers the exact visiting order and its wrap, the pass count of single-shot and re-triggered runs, the wake-up latency, and the discard and restart after an aborted conversion. The scenarios sweep every single-shot code against all eight enable patterns and run several continuous code and enable pairs.

// File: rtl/mon_conv_seq_pkg.sv
package mon_conv_seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_WAKE,
    ST_ISSUE,
    ST_WAIT
  } seq_state_e;

  typedef struct packed {
    logic run;
    logic once;
    logic shunt;
    logic bus;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(logic [2:0] m);
    mode_dec_t d;
    d.run   = (m[1:0] != 2'b00);
    d.once  = ~m[2];
    d.shunt = m[0];
    d.bus   = m[1];
    return d;
  endfunction

endpackage

// File: rtl/conv_step_pick.sv
module conv_step_pick #(
  parameter int NS = 6,
  parameter int SW = 3
) (
  input  logic [NS-1:0] vld_i,
  input  logic [SW-1:0] from_i,
  output logic          hit_o,
  output logic [SW-1:0] idx_o
);

  // lowest valid step at or above from_i
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (vld_i[i] && (SW'(i) >= from_i)) begin
        hit_o = 1'b1;
        idx_o = SW'(i);
      end
    end
  end

endmodule

// File: rtl/conv_wake_timer.sv
module conv_wake_timer #(
  parameter int WAKE_CYC = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic expire_o
);

  localparam int TW = $clog2(WAKE_CYC + 1);

  logic [TW-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == TW'(WAKE_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (run_i && !expire_o) begin
      cnt_q <= cnt_q + TW'(1);
    end
  end

endmodule

// File: rtl/conv_res_bank.sv
module conv_res_bank #(
  parameter int NCH = 3,
  parameter int DW  = 16,
  parameter int CW  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [CW-1:0]   chan_i,
  input  logic            bus_i,
  input  logic [DW-1:0]   data_i,
  output logic [NCH*DW-1:0] shunt_o,
  output logic [NCH*DW-1:0] bus_o
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] sh_q, bs_q;
    logic          sel;

    assign sel = we_i && (chan_i == CW'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q <= '0;
        bs_q <= '0;
      end else if (sel) begin
        if (bus_i) bs_q <= data_i;
        else       sh_q <= data_i;
      end
    end

    assign shunt_o[c*DW +: DW] = sh_q;
    assign bus_o[c*DW +: DW]   = bs_q;
  end

endmodule

// File: rtl/mon_conv_seq.sv
module mon_conv_seq
  import mon_conv_seq_pkg::*;
#(
  parameter int NCH      = 3,
  parameter int DW       = 16,
  parameter int WAKE_CYC = 5000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [2:0]             cfg_mode_i,
  input  logic [NCH-1:0]         cfg_chen_i,
  input  logic                   flag_rd_i,
  output logic                   adc_start_o,
  output logic [$clog2(NCH)-1:0] adc_chan_o,
  output logic                   adc_bus_o,
  input  logic                   adc_done_i,
  input  logic [DW-1:0]          adc_data_i,
  output logic [NCH*DW-1:0]      shunt_res_o,
  output logic [NCH*DW-1:0]      bus_res_o,
  output logic                   conv_rdy_o,
  output logic                   pwr_down_o
);

  localparam int CW = $clog2(NCH);
  localparam int NS = 2 * NCH;
  localparam int SW = $clog2(NS + 1);

  seq_state_e     state_q;
  logic [2:0]     mode_q;
  logic [NCH-1:0] chen_q;
  logic [SW-1:0]  ptr_q, cur_q;
  logic           drop_q, rdy_q;

  mode_dec_t      mdec, wdec;
  logic [NS-1:0]  vmask;
  logic [SW-1:0]  pick_from, pick_idx, tag_idx;
  logic           pick_hit, start_raw, acc, pass_end;
  logic           wake_exp, rdy_set, rdy_clr, wr_empty_once;

  assign mdec = decode_mode(mode_q);
  assign wdec = decode_mode(cfg_mode_i);

  // step 2c = shunt of channel c, step 2c+1 = bus of channel c
  for (genvar c = 0; c < NCH; c++) begin : g_mask
    assign vmask[2*c]   = chen_q[c] & mdec.shunt;
    assign vmask[2*c+1] = chen_q[c] & mdec.bus;
  end

  assign pick_from = (state_q == ST_WAIT) ? cur_q + SW'(1) : ptr_q;

  conv_step_pick #(.NS(NS), .SW(SW)) u_pick (
    .vld_i  (vmask),
    .from_i (pick_from),
    .hit_o  (pick_hit),
    .idx_o  (pick_idx)
  );

  conv_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cfg_we_i),
    .run_i    (state_q == ST_WAKE),
    .expire_o (wake_exp)
  );

  assign start_raw = (state_q == ST_ISSUE) && pick_hit && !drop_q;
  assign acc       = (state_q == ST_WAIT) && adc_done_i && !cfg_we_i;
  assign pass_end  = acc && !pick_hit;

  assign wr_empty_once = cfg_we_i && wdec.run && wdec.once && (cfg_chen_i == '0);
  assign rdy_set = pass_end || wr_empty_once;
  assign rdy_clr = flag_rd_i || (cfg_we_i && wdec.run);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      mode_q  <= '0;
      chen_q  <= '0;
      ptr_q   <= '0;
      cur_q   <= '0;
      drop_q  <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      if (adc_done_i && drop_q) drop_q <= 1'b0;

      if (rdy_set)      rdy_q <= 1'b1;
      else if (rdy_clr) rdy_q <= 1'b0;

      if (cfg_we_i) begin
        mode_q <= cfg_mode_i;
        chen_q <= cfg_chen_i;
        ptr_q  <= '0;
        // a conversion in flight (or issued this cycle) is abandoned
        if ((state_q == ST_WAIT && !adc_done_i) || start_raw) drop_q <= 1'b1;
        if (!wdec.run || wr_empty_once) begin
          state_q <= ST_OFF;
        end else if (state_q == ST_OFF || state_q == ST_WAKE) begin
          state_q <= ST_WAKE;
        end else begin
          state_q <= ST_ISSUE;
        end
      end else begin
        unique case (state_q)
          ST_WAKE: if (wake_exp) state_q <= ST_ISSUE;
          ST_ISSUE: begin
            if (start_raw) begin
              cur_q   <= pick_idx;
              state_q <= ST_WAIT;
            end
          end
          ST_WAIT: begin
            if (adc_done_i) begin
              if (pick_hit) begin
                ptr_q   <= pick_idx;
                state_q <= ST_ISSUE;
              end else begin
                ptr_q   <= '0;
                state_q <= mdec.once ? ST_OFF : ST_ISSUE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  conv_res_bank #(.NCH(NCH), .DW(DW), .CW(CW)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (acc),
    .chan_i  (CW'(cur_q >> 1)),
    .bus_i   (cur_q[0]),
    .data_i  (adc_data_i),
    .shunt_o (shunt_res_o),
    .bus_o   (bus_res_o)
  );

  assign tag_idx     = (state_q == ST_WAIT) ? cur_q : pick_idx;
  assign adc_start_o = start_raw;
  assign adc_chan_o  = CW'(tag_idx >> 1);
  assign adc_bus_o   = tag_idx[0];
  assign conv_rdy_o  = rdy_q;
  assign pwr_down_o  = (state_q == ST_OFF);

endmodule

// File: rtl/mon_conv_seq_chk.sv
module mon_conv_seq_chk #(
  parameter int NCH = 3,
  parameter int DW  = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cfg_we_i,
  input logic [2:0]             cfg_mode_i,
  input logic [NCH-1:0]         cfg_chen_i,
  input logic                   flag_rd_i,
  input logic                   adc_start_o,
  input logic [$clog2(NCH)-1:0] adc_chan_o,
  input logic                   adc_bus_o,
  input logic                   adc_done_i,
  input logic [NCH*DW-1:0]      shunt_res_o,
  input logic [NCH*DW-1:0]      bus_res_o,
  input logic                   conv_rdy_o,
  input logic                   pwr_down_o
);

  logic [2:0]     last_mode;
  logic [NCH-1:0] last_chen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_mode <= '0;
      last_chen <= '0;
    end else if (cfg_we_i) begin
      last_mode <= cfg_mode_i;
      last_chen <= cfg_chen_i;
    end
  end

  assert_start_pulse_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o);

  assert_no_start_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_o |-> !adc_start_o);

  assert_skip_disabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> (((last_chen >> adc_chan_o) & NCH'(1)) != '0));

  assert_shunt_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_start_o && last_mode[1:0] == 2'b01) |-> !adc_bus_o);

  assert_bus_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_start_o && last_mode[1:0] == 2'b10) |-> adc_bus_o);

  assert_rdy_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_rdy_o) |-> $past(adc_done_i || cfg_we_i));

  assert_wr_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_mode_i[1:0] != 2'b00 && cfg_chen_i != '0) |=> !conv_rdy_o);

  assert_rd_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_rd_i && !adc_done_i && !cfg_we_i) |=> !conv_rdy_o);

  assert_pd_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_mode_i[1:0] == 2'b00 && !flag_rd_i) |=> (conv_rdy_o == $past(conv_rdy_o)));

  assert_res_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_done_i |=> ($stable(shunt_res_o) && $stable(bus_res_o)));

endmodule

bind mon_conv_seq mon_conv_seq_chk #(.NCH(NCH), .DW(DW)) u_chk (.*);

// File: tb/mon_conv_seq_tb.sv
`timescale 1ns/1ps
module mon_conv_seq_tb;

  localparam int NCH = 3;
  localparam int DW  = 16;
  localparam int WK  = 5;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           cfg_we_i = 1'b0;
  logic [2:0]     cfg_mode_i = '0;
  logic [NCH-1:0] cfg_chen_i = '0;
  logic           flag_rd_i = 1'b0;
  logic           adc_start_o;
  logic [1:0]     adc_chan_o;
  logic           adc_bus_o;
  logic           adc_done_i = 1'b0;
  logic [DW-1:0]  adc_data_i = '0;
  logic [NCH*DW-1:0] shunt_res_o, bus_res_o;
  logic           conv_rdy_o, pwr_down_o;

  mon_conv_seq #(.NCH(NCH), .DW(DW), .WAKE_CYC(WK)) u_dut (.*);

  initial forever #4 clk_i = ~clk_i;

  int total = 0, bad = 0;
  int lat = 2;
  bit busy_m = 0, abort_m = 0;
  int cnt_m, m_ch, m_bs, dseq = 0, dn_cnt = 0;
  int log_n = 0;
  int log_ch[256], log_bs[256];
  logic [DW-1:0] exp_sh[NCH], exp_bs[NCH];
  int e_ch[8], e_bs[8];
  int e_n;

  initial for (int c = 0; c < NCH; c++) begin exp_sh[c] = '0; exp_bs[c] = '0; end

  // converter model
  initial forever begin
    @(negedge clk_i);
    if (adc_done_i) begin
      adc_done_i = 1'b0;
      dn_cnt++;
      if (!abort_m) begin
        if (m_bs != 0) exp_bs[m_ch] = adc_data_i;
        else           exp_sh[m_ch] = adc_data_i;
      end
      busy_m = 0;
    end else if (busy_m) begin
      cnt_m--;
      if (cnt_m == 0) begin
        dseq++;
        adc_data_i = DW'(dseq * 37 + m_ch * 4 + m_bs);
        adc_done_i = 1'b1;
      end
    end
    if (adc_start_o) begin
      busy_m = 1; abort_m = 0; cnt_m = lat;
      m_ch = int'(adc_chan_o); m_bs = int'(adc_bus_o);
      if (log_n < 256) begin log_ch[log_n] = m_ch; log_bs[log_n] = m_bs; end
      log_n++;
    end
  end

  // a write during an outstanding conversion abandons it
  initial forever begin
    @(posedge clk_i);
    if (busy_m && cfg_we_i) abort_m = 1;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_wr(int m, int ch);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_mode_i = 3'(m); cfg_chen_i = NCH'(ch);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk_i); flag_rd_i = 1'b1;
    @(negedge clk_i); flag_rd_i = 1'b0;
    #1;
  endtask

  task automatic wait_done_pd(int maxc);
    for (int i = 0; i < maxc; i++) begin
      #1;
      if (pwr_down_o && conv_rdy_o && !busy_m) break;
      @(negedge clk_i);
    end
  endtask

  task automatic wait_log(int n, int maxc);
    for (int i = 0; i < maxc; i++) begin
      #1;
      if (log_n >= n) break;
      @(negedge clk_i);
    end
  endtask

  task automatic wait_quiet(int maxc);
    for (int i = 0; i < maxc; i++) begin
      #1;
      if (!busy_m) break;
      @(negedge clk_i);
    end
  endtask

  function automatic void build_exp(int m, int ch);
    e_n = 0;
    for (int c = 0; c < NCH; c++) begin
      if (ch[c]) begin
        if (m[0]) begin e_ch[e_n] = c; e_bs[e_n] = 0; e_n++; end
        if (m[1]) begin e_ch[e_n] = c; e_bs[e_n] = 1; e_n++; end
      end
    end
  endfunction

  task automatic chk_results(string req);
    int mism = 0;
    for (int c = 0; c < NCH; c++) begin
      if (shunt_res_o[c*DW +: DW] !== exp_sh[c]) mism++;
      if (bus_res_o[c*DW +: DW] !== exp_bs[c]) mism++;
    end
    chk(mism == 0, req, "result registers mismatching", mism, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL all watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n0, d0, mism;
    logic [DW-1:0] keep0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;

    // R1 reset state
    chk(pwr_down_o === 1'b1, "R1", "pwr_down after reset", pwr_down_o, 1);
    chk(conv_rdy_o === 1'b0, "R1", "ready after reset", conv_rdy_o, 0);
    chk(adc_start_o === 1'b0 && log_n == 0, "R1", "starts after reset", log_n, 0);
    chk(shunt_res_o == '0 && bus_res_o == '0, "R1", "results after reset", 1, 0);

    // R9 wake latency from power-down
    log_n = 0;
    cfg_wr(3, 1);
    begin
      int k = 1;
      while (!adc_start_o && k < 100) begin @(negedge clk_i); k++; end
      chk(k == WK + 1, "R9", "negedges until first start", k, WK + 1);
    end
    wait_done_pd(200);
    rd_pulse();

    // single-shot sweep: every single-shot code against every enable pattern
    for (int m = 1; m <= 3; m++) begin
      for (int ch = 0; ch < 8; ch++) begin
        log_n = 0;
        cfg_wr(m, ch);
        #1;
        if (ch == 0) begin
          chk(conv_rdy_o && pwr_down_o, "R11", "empty single-shot immediate ready/pd",
              {conv_rdy_o, pwr_down_o}, 3);
        end
        wait_done_pd(300);
        build_exp(m, ch);
        chk(log_n == e_n, "R13", $sformatf("start count m=%0d ch=%0d", m, ch), log_n, e_n);
        mism = 0;
        for (int i = 0; i < e_n && i < log_n; i++)
          if (log_ch[i] != e_ch[i] || log_bs[i] != e_bs[i]) mism++;
        chk(mism == 0, "R2", $sformatf("order/skip/type m=%0d ch=%0d (R3 R4)", m, ch), mism, 0);
        chk(pwr_down_o && conv_rdy_o, "R5", $sformatf("pd+ready after pass m=%0d ch=%0d (R7)", m, ch),
            {pwr_down_o, conv_rdy_o}, 3);
        repeat (4) @(negedge clk_i);
        #1;
        chk(log_n == e_n, "R5", "no start after single pass", log_n, e_n);
        chk_results("R12");
        rd_pulse();
        chk(conv_rdy_o == 1'b0, "R8", "read strobe clears ready", conv_rdy_o, 0);
      end
    end

    // R8 power-down write keeps flag, active write clears it
    cfg_wr(3, 7);
    wait_done_pd(300);
    cfg_wr(4, 7);
    #1;
    chk(conv_rdy_o == 1'b1, "R8", "power-down write keeps ready", conv_rdy_o, 1);
    chk(pwr_down_o == 1'b1, "R5", "code 100 powers down", pwr_down_o, 1);
    cfg_wr(1, 1);
    #1;
    chk(conv_rdy_o == 1'b0, "R8", "active write clears ready", conv_rdy_o, 0);
    wait_done_pd(300);

    // R6 identical re-trigger
    cfg_wr(3, 2);
    wait_done_pd(300);
    n0 = log_n;
    cfg_wr(3, 2);
    wait_done_pd(300);
    chk(log_n == n0 + 2, "R6", "identical write re-runs pass", log_n - n0, 2);
    chk(conv_rdy_o == 1'b1, "R6", "ready after re-run", conv_rdy_o, 1);
    rd_pulse();

    // continuous codes
    for (int m = 5; m <= 7; m++) begin
      for (int j = 0; j < 4; j++) begin
        int ch, plen, need;
        ch = (j == 0) ? 5 : (j == 1) ? 7 : (j == 2) ? 2 : 1;
        build_exp(m, ch);
        plen = e_n;
        need = 2 * plen + 1;
        log_n = 0;
        cfg_wr(m, ch);
        wait_log(need, 600);
        mism = 0;
        for (int i = 0; i < need; i++)
          if (log_ch[i] != e_ch[i % plen] || log_bs[i] != e_bs[i % plen]) mism++;
        chk(mism == 0 && log_n >= need, "R2", $sformatf("continuous wrap m=%0d ch=%0d (R4)", m, ch), mism, 0);
        chk(conv_rdy_o == 1'b1, "R7", "ready after continuous pass", conv_rdy_o, 1);
        rd_pulse();
        n0 = log_n;
        wait_log(n0 + plen + 1, 600);
        chk(conv_rdy_o == 1'b1, "R7", "ready set again by later pass", conv_rdy_o, 1);
        cfg_wr(0, ch);
        wait_quiet(100);
        n0 = log_n;
        repeat (5) @(negedge clk_i);
        #1;
        chk(pwr_down_o && log_n == n0, "R5", "code 000 stops continuous run", log_n - n0, 0);
        chk_results("R12");
        rd_pulse();
      end
    end

    // R11 continuous with nothing enabled
    n0 = log_n;
    cfg_wr(7, 0);
    repeat (30) @(negedge clk_i);
    #1;
    chk(log_n == n0 && !pwr_down_o && !conv_rdy_o, "R11", "no starts, no ready with empty enables",
        log_n - n0, 0);
    cfg_wr(0, 0);

    // R10 abort mid-conversion
    lat = 20;
    log_n = 0;
    cfg_wr(7, 7);
    wait_log(1, 100);
    keep0 = shunt_res_o[0 +: DW];
    repeat (5) @(negedge clk_i);
    n0 = log_n;
    d0 = dn_cnt;
    cfg_wr(7, 6);
    for (int i = 0; i < 100 && dn_cnt == d0; i++) @(negedge clk_i);
    #1;
    chk(log_n == n0 + 1, "R10", "starts issued during drain (incl. restart)", log_n - n0, 1);
    chk(log_ch[n0] == 1 && log_bs[n0] == 0, "R10", "restart at lowest enabled shunt",
        log_ch[n0] * 2 + log_bs[n0], 2);
    chk(shunt_res_o[0 +: DW] == keep0, "R10", "aborted result discarded",
        int'(shunt_res_o[0 +: DW]), int'(keep0));
    cfg_wr(0, 0);
    wait_quiet(200);
    lat = 2;
    chk_results("R12");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule